// File: doc/BRIEF.md
# Page Entry Associative Cache

This block keeps a small, fully associative store of page table entries that were used recently, so that address translation does not have to reach memory for every access. Software cannot see it. Each lookup presents a 7-bit virtual page number together with a mode bit that selects the Exec or the User address space. When the pair matches a valid entry, the 16-bit page table entry appears on the output in the same cycle. When it does not match, a miss indication tells the external refill logic to fetch the entry. That logic then presents the fetched entry on the fill port.

The store holds `ENTRIES` entries, 8 by default, and can be built with 24. A fill goes to a free slot if there is one, and otherwise replaces the entry that has gone unused the longest. A one-cycle flush pulse is raised whenever software writes the User map base register. The pulse drops every entry at once, because translations cached under the old map are no longer valid. Walking the page tables is left to the surrounding logic.

Top module: `page_entry_cache`

## Requirements
- R1: After reset is released, every lookup misses until a fill is accepted.
- R2: A lookup that matches a valid entry raises `hit` and drives that entry's 16-bit word on `hit_data` in the same cycle, with no register in the path. An entry filled at a clock edge is visible from the cycle after that edge.
- R3: The tag is the mode bit `{exec, vpn}` together with the page number. A lookup with the same page number but the other mode bit misses, and both modes can hold the same page number at the same time with different data.
- R4: `miss` is high exactly when `lk_valid` is high and no valid entry matches. When `lk_valid` is low, both `hit` and `miss` are low, and `hit_data` is zero whenever `hit` is low.
- R5: A `flush` pulse invalidates every entry, so every lookup in the following cycles misses.
- R6: When `flush` and `fill_valid` are high in the same cycle, the fill is discarded and the store is empty afterwards.
- R7: A fill of a tag that is not resident takes a free entry while one exists. As a result, `ENTRIES` distinct fills into an empty store all remain resident.
- R8: When every entry is valid, a fill of a new tag evicts the least recently used entry. An entry becomes most recently used when a lookup hits it or a fill writes it. In a cycle that carries both a fill and a lookup, only the fill updates the recency order.
- R9: A fill whose tag is already resident overwrites that entry's data in place and evicts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vpn | input | 7 | Virtual page number of the lookup |
| lk_exec | input | 1 | Mode of the lookup, 1 = Exec, 0 = User |
| hit | output | 1 | Lookup matched a valid entry |
| miss | output | 1 | Lookup matched nothing, so a refill is needed |
| hit_data | output | 16 | Page table entry of the matching slot, zero otherwise |
| fill_valid | input | 1 | Write a fetched entry this cycle |
| fill_vpn | input | 7 | Virtual page number of the fill |
| fill_exec | input | 1 | Mode of the fill |
| fill_data | input | 16 | Page table entry to store |
| flush | input | 1 | Invalidate all entries; wins over a fill in the same cycle |

## Verification
`hit`, `miss` and `hit_data` are due combinationally in the cycle of the lookup, and they reflect the state left by the previous rising edge. Fills, flushes and recency updates therefore take effect from the cycle that follows their edge. The driver sets inputs on the falling edge and pushes the expected outcome, which comes from an independent most-recently-used list model, at that moment. The monitor pops and compares a quarter period later, before the next rising edge, so each result is matched to the stimulus that produced it and to the state that edge left behind.

// File: rtl/pec_pkg.sv
// Package for the page entry cache.
// Holds the fixed field widths of a translation tag and the shape of the tag.
// Assumes a 7-bit page number and a 16-bit page table entry as defaults.
package pec_pkg;

    localparam int PEC_VPN_W  = 7;
    localparam int PEC_DATA_W = 16;
    localparam int PEC_TAG_W  = PEC_VPN_W + 1;

    // Tag as stored: mode bit above the virtual page number.
    typedef struct packed {
        logic                 exec;
        logic [PEC_VPN_W-1:0] vpn;
    } pec_tag_t;

    // Assemble a tag from its mode bit and page number.
    function automatic pec_tag_t pec_make_tag(input logic exec, input logic [PEC_VPN_W-1:0] vpn);
        pec_tag_t t;
        t.exec = exec;
        t.vpn  = vpn;
        return t;
    endfunction

endpackage

// File: rtl/pec_tag_store.sv
// Entry store for the page entry cache.
// Keeps a valid bit, a tag and a data word for each slot. It compares two
// tags (lookup and fill) against all slots in parallel and returns the data
// and index of the lookup match.
// Assumes that at most one valid slot holds any tag, which the victim
// selection guarantees. Assumes wr_en is already suppressed by flush.
module pec_tag_store #(
    parameter  int ENTRIES = 8,
    parameter  int TAG_W   = 8,
    parameter  int DATA_W  = 16,
    localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [TAG_W-1:0]   fl_tag,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] lk_match,
    output logic [ENTRIES-1:0] fl_match,
    output logic [DATA_W-1:0]  rd_data,
    output logic [IW-1:0]      rd_idx
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES];

    // Valid bits: cleared by reset or flush, set by a write to the slot.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and data payload: written in place, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    // Parallel comparators, one pair per slot.
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign lk_match[g] = valid_q[g] && (tag_q[g] == lk_tag);
            assign fl_match[g] = valid_q[g] && (tag_q[g] == fl_tag);
        end
    endgenerate

    // Read mux: OR of the (at most one) matching slot's data and index.
    always_comb begin
        rd_data = '0;
        rd_idx  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                rd_data = rd_data | data_q[i];
                rd_idx  = rd_idx | IW'(i);
            end
        end
    end

    assign valid_vec = valid_q;

endmodule

// File: rtl/pec_recency.sv
// Recency tracker for the page entry cache.
// Each slot carries an age. The ages always form a permutation of
// 0..ENTRIES-1; 0 is the most recent, ENTRIES-1 the least recent. Touching a
// slot sets its age to 0 and ages every slot that was younger than it.
// Assumes touch_idx is below ENTRIES whenever touch is high.
module pec_recency #(
    parameter  int ENTRIES = 8,
    localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] lru_idx
);

    logic [IW-1:0] age_q [ENTRIES];
    logic [IW-1:0] touched_age;

    // Age of the slot being touched, selected without indexing past ENTRIES.
    always_comb begin
        touched_age = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (touch_idx == IW'(i)) touched_age = age_q[i];
        end
    end

    // Age update: the reset permutation is the identity, then move-to-front.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (touch_idx == IW'(i)) begin
                    age_q[i] <= '0;
                end else if (age_q[i] < touched_age) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    // Oldest slot: the one whose age is ENTRIES-1.
    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (age_q[i] == IW'(ENTRIES - 1)) lru_idx = IW'(i);
        end
    end

endmodule

// File: rtl/pec_victim.sv
// Fill slot selection for the page entry cache.
// Priority: the slot already holding the fill tag, then the lowest-numbered
// free slot, then the least recently used slot.
// Assumes fl_match has at most one bit set.
module pec_victim #(
    parameter  int ENTRIES = 8,
    localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] fl_match,
    input  logic [IW-1:0]      lru_idx,
    output logic [IW-1:0]      wr_idx
);

    // Select the write slot according to the priority above.
    always_comb begin
        wr_idx = lru_idx;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) wr_idx = IW'(i);
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (fl_match[i]) wr_idx = IW'(i);
        end
    end

endmodule

// File: rtl/page_entry_cache.sv
// Page entry cache top.
// It answers a lookup of {mode, page} combinationally, accepts one fill per
// cycle and is cleared by a flush pulse that overrides a fill in the same cycle.
// Recency is updated by an accepted fill, or else by a lookup hit.
// Assumes the refill logic never fills during reset.
module page_entry_cache #(
    parameter  int ENTRIES = 8,
    parameter  int DATA_W  = pec_pkg::PEC_DATA_W,
    localparam int VPN_W   = pec_pkg::PEC_VPN_W,
    localparam int TAG_W   = pec_pkg::PEC_TAG_W,
    localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_exec,
    output logic              hit,
    output logic              miss,
    output logic [DATA_W-1:0] hit_data,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic              fill_exec,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              flush
);

    import pec_pkg::*;

    pec_tag_t           lk_tag;
    pec_tag_t           fl_tag;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic [DATA_W-1:0]  rd_data;
    logic [IW-1:0]      rd_idx;
    logic [IW-1:0]      lru_idx;
    logic [IW-1:0]      wr_idx;
    logic               fill_ok;
    logic               any_match;
    logic               touch;
    logic [IW-1:0]      touch_idx;

    assign lk_tag = pec_make_tag(lk_exec, lk_vpn);
    assign fl_tag = pec_make_tag(fill_exec, fill_vpn);

    // A fill is accepted only when no flush is requested.
    assign fill_ok   = fill_valid && !flush;
    assign any_match = |lk_match;

    // Lookup outputs, combinational from current state.
    always_comb begin
        hit      = lk_valid && any_match;
        miss     = lk_valid && !any_match;
        hit_data = hit ? rd_data : '0;
    end

    // Recency touch: an accepted fill has precedence over a lookup hit.
    always_comb begin
        touch     = fill_ok || (lk_valid && any_match && !flush);
        touch_idx = fill_ok ? wr_idx : rd_idx;
    end

    pec_tag_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (fill_ok),
        .wr_idx    (wr_idx),
        .wr_tag    (fl_tag),
        .wr_data   (fill_data),
        .lk_tag    (lk_tag),
        .fl_tag    (fl_tag),
        .valid_vec (valid_vec),
        .lk_match  (lk_match),
        .fl_match  (fl_match),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx)
    );

    pec_recency #(
        .ENTRIES (ENTRIES)
    ) u_recency (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .lru_idx   (lru_idx)
    );

    pec_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .valid_vec (valid_vec),
        .fl_match  (fl_match),
        .lru_idx   (lru_idx),
        .wr_idx    (wr_idx)
    );

endmodule

// File: rtl/pec_checker.sv
// Assertion checker for the page entry cache, bound to every instance of
// the top. It observes the ports and the slot valid vector only.
module pec_checker #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 7,
    parameter int DATA_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [VPN_W-1:0]   lk_vpn,
    input logic               lk_exec,
    input logic               hit,
    input logic               miss,
    input logic [DATA_W-1:0]  hit_data,
    input logic               fill_valid,
    input logic [VPN_W-1:0]   fill_vpn,
    input logic               fill_exec,
    input logic [DATA_W-1:0]  fill_data,
    input logic               flush,
    input logic [ENTRIES-1:0] valid_vec
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_vec == '0)); // R1

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_valid && !flush) && lk_valid &&
         lk_vpn == $past(fill_vpn) && lk_exec == $past(fill_exec))
        |-> (hit && hit_data == $past(fill_data))); // R2

    AST_LOOKUP_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (hit != miss)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!hit && !miss && hit_data == '0)); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0 && !hit)); // R5

    AST_FILL_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=> ($countones(valid_vec) >= $past($countones(valid_vec)))); // R7

endmodule

bind page_entry_cache pec_checker #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .DATA_W  (DATA_W)
) u_pec_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vpn     (lk_vpn),
    .lk_exec    (lk_exec),
    .hit        (hit),
    .miss       (miss),
    .hit_data   (hit_data),
    .fill_valid (fill_valid),
    .fill_vpn   (fill_vpn),
    .fill_exec  (fill_exec),
    .fill_data  (fill_data),
    .flush      (flush),
    .valid_vec  (valid_vec)
);

// File: tb/tb_page_entry_cache.sv
// Scoreboard bench for the page entry cache. The driver applies one cycle of
// stimulus on the falling edge and queues the expected lookup result, taken
// from a most-recently-used list model. The monitor checks it a quarter
// period later.
module tb_page_entry_cache;

    localparam int PERIOD  = 10;
    localparam int ENTRIES = 8;
    localparam int WATCHDOG_CYCLES = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [6:0]  lk_vpn = '0;
    logic        lk_exec = 1'b0;
    logic        hit;
    logic        miss;
    logic [15:0] hit_data;
    logic        fill_valid = 1'b0;
    logic [6:0]  fill_vpn = '0;
    logic        fill_exec = 1'b0;
    logic [15:0] fill_data = '0;
    logic        flush = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Scoreboard queues.
    bit          q_hit  [$];
    bit          q_miss [$];
    logic [15:0] q_data [$];
    string       q_req  [$];

    // Model: tags and data, most recently used first.
    int          m_tag  [$];
    logic [15:0] m_data [$];

    page_entry_cache #(.ENTRIES(ENTRIES)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_exec(lk_exec),
        .hit(hit), .miss(miss), .hit_data(hit_data),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_exec(fill_exec),
        .fill_data(fill_data), .flush(flush)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic int m_find(input int tag);
        for (int i = 0; i < m_tag.size(); i++) if (m_tag[i] == tag) return i;
        return -1;
    endfunction

    // Driver: one cycle of stimulus, expected item pushed, model advanced.
    task automatic step(input bit lk, input int ltag, input bit fv, input int ftag,
                        input logic [15:0] fd, input bit fl, input string req);
        int idx;
        bit eh;
        logic [15:0] ed;
        @(negedge clk);
        lk_valid   = lk;
        lk_exec    = ltag[7];
        lk_vpn     = ltag[6:0];
        fill_valid = fv;
        fill_exec  = ftag[7];
        fill_vpn   = ftag[6:0];
        fill_data  = fd;
        flush      = fl;
        idx = m_find(ltag);
        eh  = lk && (idx >= 0);
        ed  = eh ? m_data[idx] : 16'h0;
        q_hit.push_back(eh);
        q_miss.push_back(lk && !eh);
        q_data.push_back(ed);
        q_req.push_back(req);
        if (fl) begin
            m_tag.delete();
            m_data.delete();
        end else if (fv) begin
            int j;
            j = m_find(ftag);
            if (j >= 0) begin
                m_tag.delete(j);
                m_data.delete(j);
            end
            m_tag.push_front(ftag);
            m_data.push_front(fd);
            if (m_tag.size() > ENTRIES) begin
                void'(m_tag.pop_back());
                void'(m_data.pop_back());
            end
        end else if (eh) begin
            int t;
            logic [15:0] d;
            t = m_tag[idx];
            d = m_data[idx];
            m_tag.delete(idx);
            m_data.delete(idx);
            m_tag.push_front(t);
            m_data.push_front(d);
        end
    endtask

    task automatic look(input int tag, input string req);
        step(1'b1, tag, 1'b0, 0, 16'h0, 1'b0, req);
    endtask

    task automatic fill(input int tag, input logic [15:0] d, input string req);
        step(1'b0, 0, 1'b1, tag, d, 1'b0, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Monitor: pop one expected item per cycle and compare.
    initial begin
        forever begin
            @(negedge clk);
            #(PERIOD/4);
            if (q_hit.size() > 0) begin
                bit eh, em;
                logic [15:0] ed;
                string r;
                eh = q_hit.pop_front();
                em = q_miss.pop_front();
                ed = q_data.pop_front();
                r  = q_req.pop_front();
                n_checks++;
                if (hit !== eh || miss !== em || hit_data !== ed) begin
                    n_errors++;
                    $display("FAIL %s: hit=%0b miss=%0b data=%h expected hit=%0b miss=%0b data=%h",
                             r, hit, miss, hit_data, eh, em, ed);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG_CYCLES) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG_CYCLES);
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, both modes.
        look(8'h00, "R1");
        look(8'h85, "R1");
        // R4: no lookup, both flags low.
        step(1'b0, 8'h05, 1'b0, 0, 16'h0, 1'b0, "R4");

        // R7: fill every slot with distinct User tags, then all hit (R2).
        for (int i = 0; i < ENTRIES; i++) fill(i, 16'hA000 + 16'(i), "R7");
        for (int i = 0; i < ENTRIES; i++) look(i, "R2");
        look(8'h40, "R4");

        // R3: same page, Exec mode, misses; then both modes coexist.
        look(8'h83, "R3");
        fill(8'h83, 16'hE003, "R3");
        look(8'h00, "R8");
        look(8'h03, "R3");
        look(8'h83, "R3");

        // R9: refill of a resident tag changes data, evicts nothing.
        fill(8'h05, 16'h5555, "R9");
        for (int i = 1; i < ENTRIES; i++) look(i, "R9");
        look(8'h83, "R9");

        // R8: make slot holding tag 1 recent, fill two new tags.
        look(8'h01, "R8");
        fill(8'h20, 16'h2020, "R8");
        fill(8'h21, 16'h2121, "R8");
        look(8'h01, "R8");
        look(8'h02, "R8");
        look(8'h04, "R8");
        // R8: fill with a concurrent hit; only the fill updates recency.
        step(1'b1, 8'h06, 1'b1, 8'h22, 16'h2222, 1'b0, "R8");
        fill(8'h23, 16'h2323, "R8");
        look(8'h06, "R8");
        look(8'h22, "R8");

        // R5: flush clears everything.
        step(1'b0, 0, 1'b0, 0, 16'h0, 1'b1, "R5");
        look(8'h22, "R5");
        look(8'h83, "R5");
        look(8'h01, "R5");

        // R6: flush and fill together, fill discarded.
        fill(8'h10, 16'h1010, "R6");
        step(1'b0, 0, 1'b1, 8'h11, 16'h1111, 1'b1, "R6");
        look(8'h11, "R6");
        look(8'h10, "R6");

        // R8: pseudo-random lookups with refill on miss, 32 tags over the slots.
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            int t;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            t = {24'h0, lfsr[5], 3'b000, lfsr[4:1]};
            if (m_find(t) < 0) begin
                look(t, "R8");
                fill(t, lfsr ^ 16'h3C5A, "R8");
            end
            look(t, "R2");
        end

        step(1'b0, 0, 1'b0, 0, 16'h0, 1'b0, "R4");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule